// File: doc/BRIEF.md
# Integer Fused Multiply-Accumulate Execution Unit

This unit is a multi-cycle execute slot for a 32-bit integer core. It takes a raw four-register instruction word and three source operand values with a start strobe. It decodes the word and works out whether the encoding is legal. It then forms a full-width product and adds or subtracts the third operand, optionally negating the product first. Operands are treated as two's complement or as unsigned, depending on the variant.

The result, the destination index, a write enable, an illegal flag and an overflow flag are presented together with a one-cycle done pulse. The done pulse comes a fixed three cycles after the start is taken. While an operation is in flight the unit reports busy and ignores further starts. The surrounding core handles register reads, writeback and hazards.

Top module: `imfma_unit`

## Requirements
- R1: Instruction field positions are: bits [31:27] third source index, [26:25] f2, [24:20] second source index, [19:15] first source index, [14:12] f3, [11:7] destination index, [6:0] opcode. Opcode 0x0B with f3=0 and f2=0 returns the low 32 bits of a*b+c, with all operands taken as signed.
- R2: f3=0, f2=1 returns the low 32 bits of a*b+c with all operands zero-extended.
- R3: f3=0 with f2=2 returns a*b-c signed; f3=0 with f2=3 returns a*b-c unsigned. Both return the low 32 bits.
- R4: f3=1, f2=0 returns -(a*b)+c and f3=1, f2=1 returns -(a*b)-c. Both are signed and return the low 32 bits.
- R5: An opcode other than 0x0B raises illegal in the done cycle with write enable and overflow low. So does f3=1 with f2 of 2 or 3, and so does f3 of 2 or more.
- R6: done is high for exactly one cycle, the third cycle after the cycle in which start is accepted. The illegal, overflow and write enable outputs are low outside the done cycle.
- R7: busy is high from the cycle after acceptance through the done cycle. A start while busy is ignored. Instruction and operands are captured at acceptance, so later input changes do not affect the result.
- R8: Write enable is high in the done cycle only for a legal instruction with a nonzero destination index. The destination index output carries bits [11:7].
- R9: For a legal instruction, overflow is high in the done cycle when the exact result lies outside the 32-bit range of the variant's signedness (signed: -2^31..2^31-1, unsigned: 0..2^32-1).
- R10: After reset, busy, done, write enable, illegal and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, taken when not busy |
| insn | input | 32 | Raw instruction word |
| src_a | input | 32 | First source operand value |
| src_b | input | 32 | Second source operand value |
| src_c | input | 32 | Third source operand value (addend) |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| rd_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Destination write enable, valid with done |
| result | output | 32 | Result data |
| illegal | output | 1 | Illegal encoding, valid with done |
| ovf | output | 1 | Exact result out of range, valid with done |

## Verification
The assertions rely on start being a clean level sampled at the clock edge. They also rely on nothing being expected of a start raised while busy other than that it is dropped. The stimulus raises start only in the idle cycle before each operation, plus a deliberate extra start in the first busy cycle. After acceptance it scrambles the instruction and operands, so both the ignore rule and the capture rule are exercised. Operand values come from a small set of corner values, including zero, one, minus one and the signed extremes. This set drives every legal variant into and out of overflow, and the destination index is rotated so that index zero occurs.

// File: rtl/imfma_pkg.sv
package imfma_pkg;

    localparam int ILEN = 32;
    localparam int REG_IDX_W = 5;
    localparam logic [6:0] OPC_FMA = 7'h0B;

    localparam int OPC_LSB = 0;
    localparam int RD_LSB  = 7;
    localparam int F3_LSB  = 12;
    localparam int F2_LSB  = 25;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } imfma_seq_e;

    typedef struct packed {
        logic                 legal;
        logic                 uns;
        logic                 sub;
        logic                 neg;
        logic [REG_IDX_W-1:0] rd;
    } imfma_op_t;

    function automatic logic is_legal(input logic [6:0] opc, input logic [1:0] f2,
                                      input logic [2:0] f3);
        if (opc != OPC_FMA) return 1'b0;
        if (f3 == 3'd0) return 1'b1;
        if (f3 == 3'd1) return !f2[1];
        return 1'b0;
    endfunction

endpackage

// File: rtl/imfma_decode.sv
module imfma_decode
    import imfma_pkg::*;
(
    input  logic [ILEN-1:0] insn,
    output imfma_op_t       op
);
    logic [6:0] opc;
    logic [1:0] f2;
    logic [2:0] f3;
    logic       unused_fields;

    assign opc = insn[OPC_LSB +: 7];
    assign f2  = insn[F2_LSB +: 2];
    assign f3  = insn[F3_LSB +: 3];
    assign unused_fields = ^{insn[31:27], insn[24:15]};

    always_comb begin
        op.legal = is_legal(opc, f2, f3);
        op.rd    = insn[RD_LSB +: REG_IDX_W];
        op.neg   = (f3 == 3'd1);
        op.uns   = (f3 == 3'd0) && f2[0];
        op.sub   = (f3 == 3'd0) ? f2[1] : f2[0];
    end
endmodule

// File: rtl/imfma_datapath.sv
module imfma_datapath
    import imfma_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  imfma_op_t        op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    input  logic [XLEN-1:0]  c,
    output logic [XLEN-1:0]  res,
    output logic             ovf
);
    localparam int W   = 2 * XLEN + 2;
    localparam int EXT = W - XLEN;

    logic signed [W-1:0] ea, eb, ec, prod, term, sum;

    always_comb begin
        ea = op.uns ? $signed({{EXT{1'b0}}, a}) : $signed({{EXT{a[XLEN-1]}}, a});
        eb = op.uns ? $signed({{EXT{1'b0}}, b}) : $signed({{EXT{b[XLEN-1]}}, b});
        ec = op.uns ? $signed({{EXT{1'b0}}, c}) : $signed({{EXT{c[XLEN-1]}}, c});
        prod = ea * eb;
        term = op.neg ? -prod : prod;
        sum  = op.sub ? (term - ec) : (term + ec);
    end

    assign res = sum[XLEN-1:0];

    always_comb begin
        if (op.uns)
            ovf = |sum[W-1:XLEN];
        else
            ovf = !((&sum[W-1:XLEN-1]) || !(|sum[W-1:XLEN-1]));
    end
endmodule

// File: rtl/imfma_seq.sv
module imfma_seq
    import imfma_pkg::*;
#(
    parameter int EXTRA_LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output logic busy,
    output logic done
);
    localparam int CW = (EXTRA_LAT > 1) ? $clog2(EXTRA_LAT) : 1;

    imfma_seq_e    state;
    logic [CW-1:0] cnt;

    assign busy   = (state == SEQ_RUN);
    assign accept = start && (state == SEQ_IDLE);
    assign done   = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (start) begin
                    state <= SEQ_RUN;
                    cnt   <= CW'(EXTRA_LAT - 1);
                end
                SEQ_RUN: begin
                    if (cnt == '0) state <= SEQ_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/imfma_unit.sv
module imfma_unit
    import imfma_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int EXTRA_LAT = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [ILEN-1:0]      insn,
    input  logic [XLEN-1:0]      src_a,
    input  logic [XLEN-1:0]      src_b,
    input  logic [XLEN-1:0]      src_c,
    output logic                 busy,
    output logic                 done,
    output logic [REG_IDX_W-1:0] rd_idx,
    output logic                 wr_en,
    output logic [XLEN-1:0]      result,
    output logic                 illegal,
    output logic                 ovf
);
    imfma_op_t       dec_op, op_q;
    logic [XLEN-1:0] a_q, b_q, c_q;
    logic            accept;
    logic            dp_ovf;

    imfma_decode u_dec (.insn(insn), .op(dec_op));

    imfma_seq #(.EXTRA_LAT(EXTRA_LAT)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .accept(accept), .busy(busy), .done(done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0;
            a_q  <= '0;
            b_q  <= '0;
            c_q  <= '0;
        end else if (accept) begin
            op_q <= dec_op;
            a_q  <= src_a;
            b_q  <= src_b;
            c_q  <= src_c;
        end
    end

    imfma_datapath #(.XLEN(XLEN)) u_dp (
        .op(op_q), .a(a_q), .b(b_q), .c(c_q),
        .res(result), .ovf(dp_ovf)
    );

    assign rd_idx  = op_q.rd;
    assign wr_en   = done && op_q.legal && (op_q.rd != '0);
    assign illegal = done && !op_q.legal;
    assign ovf     = done && op_q.legal && dp_ovf;
endmodule

// File: rtl/imfma_unit_chk.sv
module imfma_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [4:0]      rd_idx,
    input logic            wr_en,
    input logic [XLEN-1:0] result,
    input logic            illegal,
    input logic            ovf
);
    logic take;
    assign take = start && !busy;

    AST_DONE_AFTER_THREE: assert property (@(posedge clk) disable iff (rst) take |-> ##3 done); // R6
    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst) done |-> $past(take, 3)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
    AST_FLAGS_AT_DONE: assert property (@(posedge clk) disable iff (rst) !done |-> !(wr_en || illegal || ovf)); // R6
    AST_BUSY_ON_TAKE: assert property (@(posedge clk) disable iff (rst) take |=> busy); // R7
    AST_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> ($stable(result) && $stable(rd_idx))); // R7
    AST_NO_X0_WRITE: assert property (@(posedge clk) disable iff (rst) wr_en |-> (rd_idx != 5'd0)); // R8
    AST_ILLEGAL_NO_WE: assert property (@(posedge clk) disable iff (rst) illegal |-> (!wr_en && !ovf)); // R5
endmodule

bind imfma_unit imfma_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .rd_idx(rd_idx), .wr_en(wr_en), .result(result),
    .illegal(illegal), .ovf(ovf)
);

// File: tb/imfma_unit_tb.sv
module imfma_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] insn = '0, src_a = '0, src_b = '0, src_c = '0;
    logic        busy, done, wr_en, illegal, ovf;
    logic [4:0]  rd_idx;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    imfma_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .insn(insn),
        .src_a(src_a), .src_b(src_b), .src_c(src_c),
        .busy(busy), .done(done), .rd_idx(rd_idx), .wr_en(wr_en),
        .result(result), .illegal(illegal), .ovf(ovf)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] f2, input logic [2:0] f3,
                                       input logic [4:0] rd, input logic [6:0] opc);
        return {5'd3, f2, 5'd2, 5'd1, f3, rd, opc};
    endfunction

    task automatic run_op(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input bit poke);
        logic [6:0] opc = ins[6:0];
        logic [1:0] f2  = ins[26:25];
        logic [2:0] f3  = ins[14:12];
        logic [4:0] rd  = ins[11:7];
        bit legal, uns, neg, sub, eovf, ewe;
        logic signed [127:0] ea, eb, ec, r;
        string tag;
        legal = (opc == 7'h0B) && ((f3 == 3'd0) || (f3 == 3'd1 && f2 < 2'd2));
        uns = (f3 == 3'd0) && (f2 == 2'd1 || f2 == 2'd3);
        neg = (f3 == 3'd1);
        sub = (f3 == 3'd0) ? (f2 >= 2'd2) : (f2 == 2'd1);
        ea = uns ? $signed({96'd0, a}) : $signed({{96{a[31]}}, a});
        eb = uns ? $signed({96'd0, b}) : $signed({{96{b[31]}}, b});
        ec = uns ? $signed({96'd0, c}) : $signed({{96{c[31]}}, c});
        r = ea * eb;
        if (neg) r = -r;
        r = sub ? r - ec : r + ec;
        if (uns) eovf = (r < 0) || (r > $signed(128'd4294967295));
        else     eovf = (r > $signed(128'd2147483647)) || (r < -$signed(128'd2147483648));
        eovf = eovf && legal;
        ewe = legal && (rd != 5'd0);
        tag = neg ? "R4" : (f2 == 2'd0 ? "R1" : (f2 == 2'd1 ? "R2" : "R3"));

        @(negedge clk);
        start = 1'b1; insn = ins; src_a = a; src_b = b; src_c = c;
        @(negedge clk);
        start = poke; insn = ~ins; src_a = ~a; src_b = b + 32'd7; src_c = ~c;
        chk(busy && !done, "R7 busy after accept", {62'd0, busy, done}, 64'h2);
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R6 no early done", {63'd0, done}, 64'd0);
        @(negedge clk);
        chk(done && busy, "R6 done in third cycle", {62'd0, busy, done}, 64'h3);
        chk(illegal == !legal, "R5 illegal flag", {63'd0, illegal}, {63'd0, !legal});
        chk(wr_en == ewe, "R8 write enable", {63'd0, wr_en}, {63'd0, ewe});
        chk(rd_idx == rd, "R8 destination index", {59'd0, rd_idx}, {59'd0, rd});
        if (legal) begin
            chk(result == r[31:0], tag, {32'd0, result}, {32'd0, r[31:0]});
            chk(ovf == eovf, "R9 overflow", {63'd0, ovf}, {63'd0, eovf});
        end else begin
            chk(!ovf, "R5 no overflow when illegal", {63'd0, ovf}, 64'd0);
        end
        @(negedge clk);
        chk(!done && !busy && !wr_en && !illegal, "R6 single done pulse",
            {60'd0, done, busy, wr_en, illegal}, 64'd0);
    endtask

    logic [31:0] vals [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                              32'h8000_0000, 32'h3, 32'h0000_3039, 32'hDEAD_BEEF};

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !wr_en && !illegal && !ovf, "R10 reset state",
            {59'd0, busy, done, wr_en, illegal, ovf}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R10 idle after reset", {62'd0, busy, done}, 64'd0);

        for (int v = 0; v < 6; v++) begin
            logic [1:0] f2 = (v < 4) ? v[1:0] : v[1:0];
            logic [2:0] f3 = (v < 4) ? 3'd0 : 3'd1;
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int k = 0; k < 8; k++) begin
                        logic [4:0] rd = 5'((i * 8 + j + k + v) % 32);
                        run_op(mk(f2, f3, rd, 7'h0B), vals[i], vals[j], vals[k], k == 0);
                    end
        end

        for (int o = 0; o < 4; o++) begin
            logic [6:0] opc;
            case (o)
                0: opc = 7'h0B;
                1: opc = 7'h33;
                2: opc = 7'h0A;
                default: opc = 7'h2B;
            endcase
            for (int f3i = 0; f3i < 8; f3i++)
                for (int f2i = 0; f2i < 4; f2i++)
                    run_op(mk(2'(f2i), 3'(f3i), 5'(f3i + 1), opc),
                           32'h0000_1234, 32'hFFFF_FF00, 32'h0000_0055, 1'b1);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule